// File: doc/BRIEF.md
# Flash read timing sequencer

This block sits between a processor read port and a flash bank. It paces each read and returns the data to the requester. A read starts when the requester raises its request while the sequencer is idle. At that clock edge the address is latched and presented to the flash for the whole access. The access then lasts one base cycle plus a programmable number of wait states. During the access the block produces a bank clock. Its high time and the edge it starts on are both programmable. A 4-bit count sets the wait states, a 2-bit code sets the high time, one bit selects the alignment, and one bit chooses between a registered data return and a pass-through data return.

The bank clock is built from one register clocked on the rising edge and one clocked on the falling edge, joined through a multiplexer controlled by the system clock. No generated clock is needed. The configuration word is sampled only when a read is accepted. A request that arrives while a read is in progress stays pending until the block is idle again. A request also stays pending while half-cycles of the previous bank clock pulse are still due.

Cycle numbering below: cycle 0 is the clock cycle that follows the edge at which a request was accepted.

Top module: `flash_read_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, bankClk, rdReady, rdData and flAddr are all zero.
- R2: Configuration bits [3:0] give the wait-state count W (0 to 15). The access occupies cycles 0 to W, so the flash data is taken in cycle W.
- R3: With configuration bit 4 = 1 (pass-through), rdReady is high in cycle W and rdData equals flData of that same cycle.
- R4: With configuration bit 4 = 0 (registered), rdReady is high in cycle W+1 and rdData equals the flData present in cycle W. The flData of cycle W+1 has no effect on it.
- R5: Configuration bits [7:6] = m give a single bank clock high interval of m+1 half-cycles: 00 is half a cycle (one system-clock pulse), 01 is 1 cycle, 10 is 1.5 cycles and 11 is 2 cycles.
- R6: Configuration bit 5 = 0 makes the bank clock rise at the start of cycle 0. Bit 5 = 1 makes it rise at the falling edge in the middle of cycle 0.
- R7: rdReady is high for exactly one cycle per accepted read and is never high in two consecutive cycles.
- R8: A request present while a read is in progress is not accepted: flAddr keeps the current address. It is accepted at the first idle cycle after the read completes.
- R9: A new read is not accepted while half-cycles of the previous bank clock pulse are still to come. The new pulse never overlaps the old one.
- R10: The configuration is sampled only at acceptance. Changing it during a read alters neither the wait count, the data mode nor the bank clock shape of that read.
- R11: flAddr shows the accepted address from cycle 0 on and changes only when a new read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both edges are used for the bank clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Read request, held by the requester until it is accepted |
| rdAddr | input | ADDR_W | Read address, sampled at acceptance |
| rdCfg | input | 8 | Timing configuration: [7:6] high time, [5] alignment, [4] pass-through, [3:0] wait states |
| flData | input | DATA_W | Data bus from the flash bank |
| flAddr | output | ADDR_W | Latched address driven to the flash bank |
| bankClk | output | 1 | Bank clock toward the flash bank |
| rdReady | output | 1 | One-cycle marker that rdData is valid |
| rdData | output | DATA_W | Read data returned to the requester |

## Verification
Two events can fall in the same cycle: a new request becoming acceptable, and the tail of the previous bank clock pulse still being due. This happens most easily with pass-through, zero wait states and the longest, falling-edge-aligned pulse. The bench provokes it by holding the request high across a whole read with that setting. It judges the result by the cycles in which rdReady rises (0 and 3 only), by when flAddr switches to the second address, and by the bank clock of cycle 3 being low in its first half and high in its second. A second case sets a held request against an ongoing registered read to confirm the hold-off and the data returned.

// File: rtl/flrd_pkg.sv
`timescale 1ns/1ps
package flrd_pkg;

  localparam int WAIT_W     = 4;
  localparam int HALF_SLOTS = 6;

  // Field positions are the configuration word layout seen by software.
  typedef struct packed {
    logic [1:0]        hiMode;
    logic              alignFall;
    logic              passThru;
    logic [WAIT_W-1:0] waitCnt;
  } rdCfg_t;

  localparam int CFG_W = $bits(rdCfg_t);

  typedef struct packed {
    logic accept;
    logic capture;
    logic passNow;
  } seqStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RETURN = 2'd2
  } seqState_t;

  // Bit h set: bank clock high in half-cycle h, counted from the start of cycle 0.
  function automatic logic [HALF_SLOTS-1:0] halfMask(input logic [1:0] mode,
                                                     input logic fall);
    logic [HALF_SLOTS-1:0] ones;
    ones = (HALF_SLOTS'(2) << mode) - HALF_SLOTS'(1);
    return fall ? {ones[HALF_SLOTS-2:0], 1'b0} : ones;
  endfunction

endpackage

// File: rtl/flrd_ctrl.sv
`timescale 1ns/1ps
module flrd_ctrl
  import flrd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgPass,
  input  logic              clkPending,
  output seqStrb_t          strb,
  output logic              rdReady
);

  seqState_t         state;
  logic [WAIT_W-1:0] waitLeft;
  logic              passLat;
  logic              lastCyc;

  always_comb begin
    lastCyc       = (state == ST_ACCESS) && (waitLeft == '0);
    strb.accept   = (state == ST_IDLE) && rdReq && !clkPending;
    strb.capture  = lastCyc && !passLat;
    strb.passNow  = lastCyc && passLat;
    rdReady       = strb.passNow || (state == ST_RETURN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
      passLat  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.accept) begin
            state    <= ST_ACCESS;
            waitLeft <= cfgWait;
            passLat  <= cfgPass;
          end
        end
        ST_ACCESS: begin
          if (lastCyc) begin
            state <= passLat ? ST_IDLE : ST_RETURN;
          end else begin
            waitLeft <= waitLeft - 1'b1;
          end
        end
        ST_RETURN: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flrd_bankclk.sv
`timescale 1ns/1ps
module flrd_bankclk
  import flrd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic [1:0] hiMode,
  input  logic       alignFall,
  output logic       bankClk,
  output logic       clkPending
);

  localparam int REM_W = HALF_SLOTS - 2;

  logic [HALF_SLOTS-1:0] loadMask;
  logic [REM_W-1:0]      patRem;
  logic                  posHalf;
  logic                  preNeg;
  logic                  negHalf;

  assign loadMask = halfMask(hiMode, alignFall);

  // Rising-edge side: decides the first half of each cycle and stages the second.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patRem  <= '0;
      posHalf <= 1'b0;
      preNeg  <= 1'b0;
    end else if (accept) begin
      posHalf <= loadMask[0];
      preNeg  <= loadMask[1];
      patRem  <= loadMask[HALF_SLOTS-1:2];
    end else begin
      posHalf <= patRem[0];
      preNeg  <= patRem[1];
      patRem  <= {2'b00, patRem[REM_W-1:2]};
    end
  end

  // Falling-edge side: owns the second half of each cycle.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negHalf <= 1'b0;
    else       negHalf <= preNeg;
  end

  assign bankClk    = clk ? posHalf : negHalf;
  assign clkPending = |patRem;

endmodule

// File: rtl/flrd_dpath.sv
`timescale 1ns/1ps
module flrd_dpath
  import flrd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] flData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flAddr <= '0;
      dataQ  <= '0;
    end else begin
      if (strb.accept)  flAddr <= rdAddr;
      if (strb.capture) dataQ  <= flData;
    end
  end

  assign rdData = strb.passNow ? flData : dataQ;

endmodule

// File: rtl/flash_read_sequencer.sv
`timescale 1ns/1ps
module flash_read_sequencer
  import flrd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CFG_W-1:0]  rdCfg,
  input  logic [DATA_W-1:0] flData,
  output logic [ADDR_W-1:0] flAddr,
  output logic              bankClk,
  output logic              rdReady,
  output logic [DATA_W-1:0] rdData
);

  rdCfg_t   cfgS;
  seqStrb_t strb;
  logic     clkPending;

  assign cfgS = rdCfg_t'(rdCfg);

  flrd_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdReq      (rdReq),
    .cfgWait    (cfgS.waitCnt),
    .cfgPass    (cfgS.passThru),
    .clkPending (clkPending),
    .strb       (strb),
    .rdReady    (rdReady)
  );

  flrd_bankclk i_bankclk (
    .clk        (clk),
    .rstN       (rstN),
    .accept     (strb.accept),
    .hiMode     (cfgS.hiMode),
    .alignFall  (cfgS.alignFall),
    .bankClk    (bankClk),
    .clkPending (clkPending)
  );

  flrd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdAddr (rdAddr),
    .flData (flData),
    .flAddr (flAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/flrd_checker.sv
`timescale 1ns/1ps
module flrd_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] flData,
  input logic [ADDR_W-1:0] flAddr,
  input logic              accept,
  input logic              passNow
);

  // R7: ready is a single-cycle marker
  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !rdReady);

  // R11: the flash address moves only on acceptance
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(flAddr));

  // R4: registered return shows the flash data of the previous cycle
  a_r4_reg_data: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && !passNow) |-> (rdData == $past(flData)));

  // R8: no second acceptance right behind the first
  a_r8_accept_gap: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept);

endmodule

bind flash_read_sequencer flrd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdReady (rdReady),
  .rdData  (rdData),
  .flData  (flData),
  .flAddr  (flAddr),
  .accept  (strb.accept),
  .passNow (strb.passNow)
);

// File: tb/test_flash_read_sequencer.sv
`timescale 1ns/1ps
module test_flash_read_sequencer;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int NV     = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdReq = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdCfg = '0;
  logic [DATA_W-1:0] flData = '0;
  logic [ADDR_W-1:0] flAddr;
  logic              bankClk;
  logic              rdReady;
  logic [DATA_W-1:0] rdData;

  int vecCount = 0;
  int missCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_read_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_flash_read_sequencer (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdCfg(rdCfg),
    .flData(flData), .flAddr(flAddr), .bankClk(bankClk), .rdReady(rdReady),
    .rdData(rdData)
  );

  // cfg = {hiMode[1:0], alignFall, passThru, waitCnt[3:0]}
  localparam logic [7:0]  V_CFG  [NV] = '{8'h60, 8'h02, 8'h93, 8'hF0, 8'hCF, 8'h35, 8'hA1, 8'h03};
  localparam logic [7:0]  V_MID  [NV] = '{8'h60, 8'h02, 8'h93, 8'hF0, 8'hCF, 8'h35, 8'hA1, 8'hF0};
  localparam logic [19:0] V_ADDR [NV] = '{20'h00010, 20'h0ABCD, 20'hFFFFF, 20'h00001,
                                          20'h12345, 20'h54321, 20'h0F0F0, 20'h33333};
  localparam logic [31:0] V_BASE [NV] = '{32'hA5000000, 32'h11110000, 32'h22220000, 32'h33330000,
                                          32'h44440000, 32'h55550000, 32'h66660000, 32'h77770000};
  localparam logic [31:0] V_EXPD [NV] = '{32'hA5000000, 32'h11110002, 32'h22220003, 32'h33330000,
                                          32'h4444000F, 32'h55550005, 32'h66660001, 32'h77770003};
  localparam int          V_LAT  [NV] = '{1, 3, 3, 0, 16, 5, 2, 4};
  localparam logic [7:0]  V_PAT  [NV] = '{8'h06, 8'h01, 8'h07, 8'h1E, 8'h0F, 8'h02, 8'h0E, 8'h01};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [7:0] cfg, input logic [7:0] midCfg,
                        input logic [19:0] addr, input logic [31:0] base,
                        input logic [31:0] expData, input int expLat,
                        input logic [7:0] expPat, input string tag);
    int readyCnt = 0;
    int readyAt = -1;
    logic [31:0] gotData = '0;
    logic [7:0] pat = '0;
    bit extra = 1'b0;
    bit addrOk = 1'b1;
    int ncyc = expLat + 5;
    @(posedge clk); #1;
    rdCfg = cfg; rdAddr = addr; rdReq = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      if (c == 0) begin rdReq = 1'b0; rdCfg = midCfg; rdAddr = ~addr; end
      flData = base + 32'(c);
      #1;
      if (rdReady) begin
        readyCnt++;
        if (readyAt < 0) begin readyAt = c; gotData = rdData; end
      end
      if (flAddr !== addr) addrOk = 1'b0;
      if (c < 4) pat[2*c] = bankClk; else if (bankClk) extra = 1'b1;
      #4;
      if (c < 4) pat[2*c+1] = bankClk; else if (bankClk) extra = 1'b1;
    end
    check(readyAt == expLat, {tag, " R2 ready cycle"}, readyAt, expLat);
    check(readyCnt == 1, {tag, " R7 ready count"}, readyCnt, 1);
    check(gotData == expData, {tag, cfg[4] ? " R3 pass-through data" : " R4 registered data"},
          gotData, expData);
    check(pat == expPat && !extra, {tag, " R5 R6 bank clock halves"}, pat, expPat);
    check(addrOk, {tag, " R11 address held"}, addrOk, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] readyMask;
    logic [31:0] dSave;
    logic [19:0] aA, aB;
    logic        bLo, bHi;

    // R1: reset state
    repeat (2) @(posedge clk);
    #2;
    check(bankClk == 1'b0, "R1 bankClk in reset", bankClk, 0);
    check(rdReady == 1'b0, "R1 rdReady in reset", rdReady, 0);
    #1 rstN = 1'b1;
    @(posedge clk); #2;
    check(rdData == '0, "R1 rdData after reset", rdData, 0);
    check(flAddr == '0, "R1 flAddr after reset", flAddr, 0);

    // Table of vectors; the last one changes the configuration mid-read (R10)
    for (int i = 0; i < NV; i++) begin
      doRead(V_CFG[i], V_MID[i], V_ADDR[i], V_BASE[i], V_EXPD[i], V_LAT[i], V_PAT[i],
             (i == NV - 1) ? "R10 mid-read cfg" : "table");
    end

    // R8: request held during a registered read with 4 wait states
    @(posedge clk); #1;
    rdCfg = 8'h04; rdAddr = 20'hAAAAA; rdReq = 1'b1;
    readyMask = '0; dSave = '0; aA = '0; aB = '0;
    for (int c = 0; c < 17; c++) begin
      @(posedge clk); #1;
      if (c == 0) rdAddr = 20'h55555;
      if (c == 7) rdReq = 1'b0;
      flData = 32'hB0000000 + 32'(c);
      #1;
      if (rdReady) begin
        readyMask[c] = 1'b1;
        if (c == 5) dSave = rdData;
      end
      if (c == 6) aA = flAddr;
      if (c == 7) aB = flAddr;
      #4;
    end
    check(readyMask == 32'h00001020, "R8 ready cycles with held request", readyMask, 32'h1020);
    check(dSave == 32'hB0000004, "R4 data of first held read", dSave, 32'hB0000004);
    check(aA == 20'hAAAAA, "R8 address kept while busy", aA, 20'hAAAAA);
    check(aB == 20'h55555, "R8 held request accepted when idle", aB, 20'h55555);

    // R9: held request against the tail of a long late bank clock pulse
    @(posedge clk); #1;
    rdCfg = 8'hF0; rdAddr = 20'h01234; rdReq = 1'b1;
    readyMask = '0; dSave = '0; aA = '0; aB = '0; bLo = 1'b1; bHi = 1'b0;
    for (int c = 0; c < 9; c++) begin
      @(posedge clk); #1;
      if (c == 0) rdAddr = 20'h04321;
      if (c == 3) rdReq = 1'b0;
      flData = 32'hC0000000 + 32'(c);
      #1;
      if (rdReady) begin
        readyMask[c] = 1'b1;
        if (c == 3) dSave = rdData;
      end
      if (c == 2) aA = flAddr;
      if (c == 3) begin aB = flAddr; bLo = bankClk; end
      #4;
      if (c == 3) bHi = bankClk;
    end
    check(readyMask == 32'h00000009, "R9 ready cycles behind pending clock", readyMask, 32'h9);
    check(aA == 20'h01234, "R9 no acceptance while clock pending", aA, 20'h01234);
    check(aB == 20'h04321, "R9 acceptance after clock finished", aB, 20'h04321);
    check(dSave == 32'hC0000003, "R3 pass-through data of second read", dSave, 32'hC0000003);
    check(bLo == 1'b0 && bHi == 1'b1, "R9 R6 fresh pulse starts mid-cycle", {bLo, bHi}, 2'b01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule